// File: doc/BRIEF.md
# Timestamped Pixel Hit Readout with Fixed-Priority Drain

This block is the digital periphery for a column of pixels, with one readout cell for every pixel. A free-running timestamp counter advances by one on every clock. When a pixel's discriminated hit line rises, that pixel's cell freezes the current counter value and raises its hit flag. The cell then keeps the hit, unchanged, until it has been read out. Readout needs no trigger. A fixed-priority scan picks a flagged cell and presents its row, column and stored timestamp on one shared output bus together with a valid strobe. The consumer pulses an acknowledge to take the word and free the cell.

A two-state controller runs the drain. In state RD_IDLE the scan result is sampled. If any flag is set, the transition RD_IDLE to RD_SHOW (load) registers the chosen cell's address and timestamp onto the bus. If no flag is set, the transition RD_IDLE to RD_IDLE (wait) leaves the bus untouched. In RD_SHOW the word stays on the bus. With the acknowledge low, RD_SHOW to RD_SHOW (hold) keeps it there. With the acknowledge high, RD_SHOW to RD_IDLE (take) clears the presented cell. Each word is therefore followed by one cycle with valid low.

A hit that arrives on a cell whose flag is still set cannot be stored. It is discarded and counted in a saturating loss counter.

Top module: `hit_scan_readout`

## Requirements
- R1: After reset, out_valid, out_row, out_col, out_ts and ovf_count are all zero, and the timestamp counter starts from zero.
- R2: The timestamp counter counts up by one on each clock and wraps modulo 2^TS_W. When a clock edge samples hit_in[p] high after it was low at the previous edge, and cell p has no flag, cell p sets its flag and stores the counter value held just before that edge.
- R3: A flagged cell keeps its flag and its stored timestamp unchanged until that cell is taken by an acknowledge.
- R4: Only the rising edge of a hit line is seen. A hit line held high for many cycles makes a single capture, and it captures nothing more after its word has been taken.
- R5: Among the flagged cells, the one with the lowest pixel index p is presented first, whatever order the hits arrived in.
- R6: A presented word carries row = p / COLS, col = p % COLS and the timestamp stored in cell p. out_valid rises on the clock after the scan first sees a flag. The word stays on the bus with out_valid high for as long as rd_ack is low.
- R7: When rd_ack is high at a clock edge while out_valid is high, only the presented cell is cleared, and out_valid is low for the following cycle.
- R8: A rising hit on a cell whose flag is set is discarded. ovf_count increases by the number of such discards in that cycle and saturates at 2^OVF_W-1.
- R9: While no cell is flagged, out_valid stays low and out_row, out_col and out_ts keep the last word presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_in | input | ROWS*COLS | Discriminated hit line per pixel, index p = row*COLS + col |
| rd_ack | input | 1 | Takes the presented word and clears its cell |
| out_valid | output | 1 | A word is on the bus |
| out_row | output | max(1,clog2(ROWS)) | Row of the presented pixel |
| out_col | output | max(1,clog2(COLS)) | Column of the presented pixel |
| out_ts | output | TS_W | Timestamp stored at hit time |
| ovf_count | output | OVF_W | Saturating count of discarded hits |

## Verification
Several properties are checked on every cycle. A capture must load the flag and the counter value. A flagged cell must hold its timestamp and flag. The scan result must be the lowest flagged index. A held word must stay stable. An acknowledge must clear the presented cell and drop valid. The bus must hold while the block is idle, and the loss counter must never decrease. Only the bench scenarios can show the drain order for hits that arrive out of order, the address split into row and column, the wrap of the timestamp, a single capture from a long pulse, and the exact loss counts including saturation.

// File: rtl/hsr_pkg.sv
`timescale 1ns/1ps
package hsr_pkg;
    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_SHOW = 1'b1
    } rd_state_e;
endpackage

// File: rtl/hsr_tsgen.sv
`timescale 1ns/1ps
module hsr_tsgen #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_now
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_now <= '0;
        else        ts_now <= ts_now + 1'b1;
    end
endmodule

// File: rtl/hsr_cell.sv
`timescale 1ns/1ps
module hsr_cell #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic [TS_W-1:0] ts_now,
    input  logic            clr,
    output logic            flag,
    output logic [TS_W-1:0] ts_q,
    output logic            drop
);
    logic hit_q;
    logic rise;

    assign rise = hit & ~hit_q;
    assign drop = rise & flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            flag  <= 1'b0;
            ts_q  <= '0;
        end else begin
            hit_q <= hit;
            if (clr) begin
                flag <= 1'b0;
            end else if (rise && !flag) begin
                flag <= 1'b1;
                ts_q <= ts_now;
            end
        end
    end

    // R2: a fresh edge on an empty cell stores the counter value
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !flag) |=> (flag && ts_q == $past(ts_now)));

    // R3: a flagged cell keeps its contents until it is cleared
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> (flag && $stable(ts_q)));

    // R4: without a new edge an empty cell stays empty
    p_no_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !flag) |=> !flag);
endmodule

// File: rtl/hsr_prio.sv
`timescale 1ns/1ps
module hsr_prio #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     flags,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags[i]) idx = IDX_W'(i);
        end
    end

    assign any = |flags;
endmodule

// File: rtl/hit_scan_readout.sv
`timescale 1ns/1ps
module hit_scan_readout #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int TS_W  = 8,
    parameter int OVF_W = 8,
    localparam int NPIX  = ROWS * COLS,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIX-1:0]   hit_in,
    input  logic              rd_ack,
    output logic              out_valid,
    output logic [ROW_W-1:0]  out_row,
    output logic [COL_W-1:0]  out_col,
    output logic [TS_W-1:0]   out_ts,
    output logic [OVF_W-1:0]  ovf_count
);
    import hsr_pkg::*;

    localparam int IDX_W   = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam int OVF_MAX = (1 << OVF_W) - 1;

    rd_state_e          state, state_d;
    logic [TS_W-1:0]    ts_now;
    logic [NPIX-1:0]    flags, clr_v, drop_v;
    logic [TS_W-1:0]    cell_ts [NPIX];
    logic               any_flag;
    logic [IDX_W-1:0]   pick, sel;
    logic               take;
    int                 ovf_sum;
    logic [OVF_W-1:0]   ovf_d;

    hsr_tsgen #(.TS_W(TS_W)) u_ts (
        .clk(clk), .rst_n(rst_n), .ts_now(ts_now)
    );

    for (genvar g = 0; g < NPIX; g++) begin : g_cell
        assign clr_v[g] = take && (sel == IDX_W'(g));
        hsr_cell #(.TS_W(TS_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .hit(hit_in[g]), .ts_now(ts_now),
            .clr(clr_v[g]), .flag(flags[g]), .ts_q(cell_ts[g]), .drop(drop_v[g])
        );
    end

    hsr_prio #(.N(NPIX), .IDX_W(IDX_W)) u_prio (
        .flags(flags), .any(any_flag), .idx(pick)
    );

    assign take      = (state == RD_SHOW) && rd_ack;
    assign out_valid = (state == RD_SHOW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_d;
    end

    // transitions: wait, load, hold, take
    always_comb begin
        state_d = state;
        unique case (state)
            RD_IDLE: if (any_flag) state_d = RD_SHOW;
            RD_SHOW: if (rd_ack)   state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    // output word, loaded only on the load transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel     <= '0;
            out_row <= '0;
            out_col <= '0;
            out_ts  <= '0;
        end else if (state == RD_IDLE && any_flag) begin
            sel     <= pick;
            out_row <= ROW_W'(int'(pick) / COLS);
            out_col <= COL_W'(int'(pick) % COLS);
            out_ts  <= cell_ts[pick];
        end
    end

    // saturating loss counter
    always_comb begin
        ovf_sum = int'(ovf_count) + $countones(drop_v);
        ovf_d   = (ovf_sum > OVF_MAX) ? OVF_W'(OVF_MAX) : OVF_W'(ovf_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_count <= '0;
        else        ovf_count <= ovf_d;
    end

    // R5: the scan result is flagged and no lower index is flagged
    p_lowest_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_flag |-> (flags[pick] &&
            ((flags & ((NPIX'(1) << pick) - NPIX'(1))) == '0)));

    // R6: a word not yet taken stays on the bus
    p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !rd_ack) |=> (out_valid && $stable(out_row) &&
            $stable(out_col) && $stable(out_ts)));

    // R7: a take empties the presented cell and drops valid for a cycle
    p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rd_ack) |=> (!out_valid && !flags[$past(sel)]));

    // R8: the loss counter never goes down
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovf_count >= $past(ovf_count)));

    // R9: with nothing pending the bus is frozen and invalid
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !any_flag) |=> (!out_valid && $stable(out_row) &&
            $stable(out_col) && $stable(out_ts)));
endmodule

// File: tb/sim_hit_scan_readout.sv
`timescale 1ns/1ps
module sim_hit_scan_readout;
    localparam int ROWS = 4, COLS = 4, TS_W = 6, OVF_W = 2;
    localparam int NPIX = ROWS * COLS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPIX-1:0]   hit = '0;
    logic              rd_ack = 1'b0;
    logic              out_valid;
    logic [1:0]        out_row, out_col;
    logic [TS_W-1:0]   out_ts;
    logic [OVF_W-1:0]  ovf_count;

    logic [TS_W-1:0]   tb_ts;
    int                exp_ts [NPIX];
    int                checks = 0;
    int                errors = 0;

    always #2.5 clk = ~clk;

    hit_scan_readout #(.ROWS(ROWS), .COLS(COLS), .TS_W(TS_W), .OVF_W(OVF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .hit_in(hit), .rd_ack(rd_ack),
        .out_valid(out_valid), .out_row(out_row), .out_col(out_col),
        .out_ts(out_ts), .ovf_count(ovf_count)
    );

    // independent model of the free-running counter
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_ts <= '0;
        else        tb_ts <= tb_ts + 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(input int p);
        @(negedge clk);
        hit[p] = 1'b1;
        exp_ts[p] = int'(tb_ts);
        @(negedge clk);
        hit[p] = 1'b0;
    endtask

    task automatic pulse2(input int p, input int q);
        @(negedge clk);
        hit[p] = 1'b1;
        hit[q] = 1'b1;
        exp_ts[p] = int'(tb_ts);
        exp_ts[q] = int'(tb_ts);
        @(negedge clk);
        hit[p] = 1'b0;
        hit[q] = 1'b0;
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 50 && !out_valid; k++) @(negedge clk);
    endtask

    task automatic pop(input int p, input string req);
        wait_valid();
        check(out_valid == 1'b1, req, "valid", int'(out_valid), 1);
        check(int'(out_row) == p / COLS, req, "row", int'(out_row), p / COLS);
        check(int'(out_col) == p % COLS, req, "col", int'(out_col), p % COLS);
        check(int'(out_ts) == exp_ts[p], req, "ts", int'(out_ts), exp_ts[p]);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        check(out_valid == 1'b0, "R7", "valid after take", int'(out_valid), 0);
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R1", "valid", int'(out_valid), 0);
        check(out_row == 2'd0 && out_col == 2'd0, "R1", "addr",
              int'({out_row, out_col}), 0);
        check(out_ts == '0, "R1", "ts", int'(out_ts), 0);
        check(ovf_count == '0, "R1", "ovf", int'(ovf_count), 0);
    endtask

    task automatic t_single();
        pulse(6);
        wait_valid();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b1, "R6", "held valid", int'(out_valid), 1);
        check(int'(out_ts) == exp_ts[6], "R3", "held ts", int'(out_ts), exp_ts[6]);
        pop(6, "R2");
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R9", "idle valid", int'(out_valid), 0);
        check(out_row == 2'd1 && out_col == 2'd2, "R9", "bus kept",
              int'({out_row, out_col}), 6);
        check(int'(out_ts) == exp_ts[6], "R9", "ts kept", int'(out_ts), exp_ts[6]);
    endtask

    task automatic t_order();
        pulse(9);
        wait_valid();
        pulse(13);
        pulse(2);
        pulse(5);
        repeat (2) @(negedge clk);
        pop(9, "R6");
        pop(2, "R5");
        pop(5, "R5");
        pop(13, "R7");
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", "drained", int'(out_valid), 0);
    endtask

    task automatic t_wrap();
        repeat (70) @(negedge clk);
        pulse(0);
        pop(0, "R2");
        pulse(15);
        pop(15, "R2");
    endtask

    task automatic t_edge();
        @(negedge clk);
        hit[3] = 1'b1;
        exp_ts[3] = int'(tb_ts);
        pop(3, "R4");
        repeat (4) @(negedge clk);
        hit[3] = 1'b0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R4", "no recapture", int'(out_valid), 0);
        check(ovf_count == '0, "R4", "no loss", int'(ovf_count), 0);
    endtask

    task automatic t_drop();
        int keep_a;
        int keep_b;
        pulse(7);
        wait_valid();
        keep_a = exp_ts[7];
        pulse(7);
        exp_ts[7] = keep_a;
        check(int'(ovf_count) == 1, "R8", "one loss", int'(ovf_count), 1);
        pop(7, "R8");
        pulse2(1, 4);
        wait_valid();
        keep_a = exp_ts[1];
        keep_b = exp_ts[4];
        pulse2(1, 4);
        check(int'(ovf_count) == 3, "R8", "two losses", int'(ovf_count), 3);
        pulse(4);
        check(int'(ovf_count) == 3, "R8", "saturated", int'(ovf_count), 3);
        exp_ts[1] = keep_a;
        exp_ts[4] = keep_b;
        pop(1, "R8");
        pop(4, "R3");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_order();
        t_wrap();
        t_edge();
        t_drop();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule